// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides when a 16-bit timer counter advances. A 3-bit select code chooses the source of the count enable. Codes 0 to 6 pick the bus clock divided by a power of two. Code 7 picks an external clock pin. The pin is first passed through a synchroniser clocked by the bus clock. Each rising edge it shows then becomes exactly one single-cycle count-enable strobe. The counter, its modulo compare and the capture/compare channels sit outside this block and only consume the strobe.

The same pad also serves as general-purpose I/O. The block registers the pin's direction and drive value and returns the synchronised input level. While code 7 is in effect the pad is forced to act as an input, whatever its direction bit says. A stop input gates the strobe off. It leaves the synchroniser running, so no edge that arrives during the stop is released when the stop ends.

Top module: `tmr_clk_src_sel`

## Requirements
- R1: With select code n in 0..6 held and `stopReq` low, `countEn` is high for exactly one cycle in every 2^n cycles; code 0 gives a strobe in every cycle.
- R2: A new select code is registered at the first rising edge at which it differs from the held code, and that edge clears the divider. For code n in 0..6, the first strobe is then high in cycle 2^n, where the cycle that follows that edge is cycle 1.
- R3: With code 7 (binary 111), each rising edge on `pinIn` gives exactly one single-cycle `countEn` pulse. The pulse is high in the cycle that follows the second clock edge after `pinIn` rises. This holds for input rates up to half the bus clock, with each level lasting at least one bus cycle.
- R4: With code 7, falling edges and steady levels on `pinIn` produce no `countEn` pulse, and the bus prescaler produces none either.
- R5: While code 7 is registered, `pinOe` is low even when `pinDirOut` is 1.
- R6: When the registered code is not 7, `pinOe` equals `pinDirOut` and `pinOut` equals `pinDataOut`, each as sampled at the previous clock edge.
- R7: `pinRead` equals the `pinIn` value sampled two clock edges earlier, in every mode.
- R8: While `stopReq` is high, `countEn` is low. The synchroniser keeps tracking the pin, so a pin rising edge that occurs during the stop gives no pulse after the stop is released.
- R9: A clock edge with `rst` high (active-high, synchronous) clears the divider, the synchroniser and the edge detector, and sets the pin direction to input. After that edge `pinOe` is 0 and `pinRead` is 0, and the registered code becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| stopReq | input | 1 | Holds the count enable low while high |
| psSel | input | 3 | Source select: 0..6 bus clock divided by 2^code, 7 external pin |
| pinIn | input | 1 | Raw level from the shared pad |
| pinDirOut | input | 1 | Direction bit for general-purpose use, 1 = output |
| pinDataOut | input | 1 | Value to drive onto the pad in output mode |
| countEn | output | 1 | Single-cycle count-enable strobe for the timer counter |
| pinOe | output | 1 | Pad output enable |
| pinOut | output | 1 | Registered pad drive value |
| pinRead | output | 1 | Synchronised pad level |

## Verification
The properties assume that `pinIn` obeys the external clock limits: each level lasts at least one bus cycle, so no edge can fall between two synchroniser samples. They also assume that `pinIn` is low when reset is released. The stimulus changes the pin only at falling clock edges and never holds a level for less than one full cycle. Its fastest toggling is exactly half the bus rate. Select codes and the direction bit are likewise changed only at falling edges and then held, so every expected strobe position is a whole number of cycles from the edge that registered the change.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int SEL_W = 3;

  // strobes handed from the control side to the datapath each cycle
  typedef struct packed {
    logic extSel;   // external pin is the count source
    logic busTick;  // prescaled bus clock tick
    logic hold;     // suppress the count enable
  } tcsStrobe_t;

endpackage

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
  import tcs_pkg::*;
#(
  parameter int SEL_BITS = SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stopReq,
  input  logic [SEL_BITS-1:0] psSel,
  output tcsStrobe_t          strobe
);

  // largest divide code is one below the all-ones code
  localparam int MAX_CODE = (1 << SEL_BITS) - 2;
  localparam int DIV_W    = MAX_CODE;
  localparam logic [SEL_BITS-1:0] EXT_CODE = '1;

  logic [SEL_BITS-1:0] selQ;
  logic [DIV_W-1:0]    divCnt;
  logic [DIV_W-1:0]    tapMask;

  // a code change restarts the divider so the first tick is a full period away
  always_ff @(posedge clk) begin
    if (rst) begin
      selQ   <= '0;
      divCnt <= '0;
    end else if (psSel != selQ) begin
      selQ   <= psSel;
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // low selQ bits of the divider must all be ones for a tick
  for (genvar g = 0; g < DIV_W; g++) begin : gTap
    assign tapMask[g] = (int'(selQ) > g);
  end

  always_comb begin
    strobe.extSel  = (selQ == EXT_CODE);
    strobe.busTick = ((divCnt & tapMask) == tapMask);
    strobe.hold    = stopReq;
  end

endmodule

// File: rtl/tcs_datapath.sv
module tcs_datapath
  import tcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  tcsStrobe_t strobe,
  input  logic       pinIn,
  input  logic       pinDirOut,
  input  logic       pinDataOut,
  output logic       countEn,
  output logic       pinOe,
  output logic       pinOut,
  output logic       pinRead
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic dirQ;
  logic dataQ;
  logic pinRise;

  // synchroniser chain, free running even while the strobe is held off
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (rst) syncQ[0] <= 1'b0;
        else     syncQ[0] <= pinIn;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (rst) syncQ[g] <= 1'b0;
        else     syncQ[g] <= syncQ[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevQ <= 1'b0;
      dirQ  <= 1'b0;
      dataQ <= 1'b0;
    end else begin
      prevQ <= syncQ[LAST];
      dirQ  <= pinDirOut;
      dataQ <= pinDataOut;
    end
  end

  assign pinRise = syncQ[LAST] & ~prevQ;

  always_comb begin
    countEn = ~strobe.hold & (strobe.extSel ? pinRise : strobe.busTick);
    pinOe   = dirQ & ~strobe.extSel;
    pinOut  = dataQ;
    pinRead = syncQ[LAST];
  end

endmodule

// File: rtl/tmr_clk_src_sel.sv
module tmr_clk_src_sel
  import tcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             stopReq,
  input  logic [SEL_W-1:0] psSel,
  input  logic             pinIn,
  input  logic             pinDirOut,
  input  logic             pinDataOut,
  output logic             countEn,
  output logic             pinOe,
  output logic             pinOut,
  output logic             pinRead
);

  tcsStrobe_t strobe;

  tcs_ctrl #(.SEL_BITS(SEL_W)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .stopReq (stopReq),
    .psSel   (psSel),
    .strobe  (strobe)
  );

  tcs_datapath #(.SYNC_STAGES(2)) uData (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .pinIn      (pinIn),
    .pinDirOut  (pinDirOut),
    .pinDataOut (pinDataOut),
    .countEn    (countEn),
    .pinOe      (pinOe),
    .pinOut     (pinOut),
    .pinRead    (pinRead)
  );

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
  input logic       clk,
  input logic       rst,
  input logic       stopReq,
  input logic [2:0] psSel,
  input logic       pinIn,
  input logic       pinDirOut,
  input logic       pinDataOut,
  input logic       countEn,
  input logic       pinOe,
  input logic       pinOut,
  input logic       pinRead
);

  // R1: divide-by-one gives a strobe every cycle
  a_r1_div1_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(psSel) == 3'd0 && !stopReq) |-> countEn);

  // R3: an external pulse never lasts two cycles
  a_r3_ext_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(psSel) == 3'd7 && psSel == 3'd7 && countEn) |=> !countEn);

  // R5: pin is an input while the external source is registered
  a_r5_ext_forces_input: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(psSel) == 3'd7) |-> !pinOe);

  // R6: general-purpose drive value follows the data bit one edge later
  a_r6_gpio_data: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pinOut == $past(pinDataOut)));

  // R7: two-edge synchroniser latency
  a_r7_sync_latency: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (pinRead == $past(pinIn, 2)));

  // R8: stop blocks the strobe
  a_r8_stop_blocks: assert property (@(posedge clk) disable iff (rst)
    stopReq |-> !countEn);

  // R9: reset leaves the pin an input with a cleared synchroniser
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!pinOe && !pinRead));

endmodule

bind tmr_clk_src_sel tcs_checker uChk (.*);

// File: tb/tmr_clk_src_sel_test.sv
module tmr_clk_src_sel_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stopReq = 1'b0;
  logic [2:0] psSel = 3'd0;
  logic       pinIn = 1'b0;
  logic       pinDirOut = 1'b0;
  logic       pinDataOut = 1'b0;
  logic       countEn, pinOe, pinOut, pinRead;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tmr_clk_src_sel uut (
    .clk(clk), .rst(rst), .stopReq(stopReq), .psSel(psSel),
    .pinIn(pinIn), .pinDirOut(pinDirOut), .pinDataOut(pinDataOut),
    .countEn(countEn), .pinOe(pinOe), .pinOut(pinOut), .pinRead(pinRead)
  );

  // R1/R2 vectors: code, strobes seen in 100 cycles, first strobe cycle
  localparam int NVEC = 7;
  localparam logic [2:0] VEC_CODE  [NVEC] = '{3'd3, 3'd0, 3'd5, 3'd1, 3'd6, 3'd2, 3'd4};
  localparam int         VEC_COUNT [NVEC] = '{12, 100, 3, 50, 1, 25, 6};
  localparam int         VEC_FIRST [NVEC] = '{8, 1, 32, 2, 64, 4, 16};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count strobes over n cycles
  task automatic countPulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (countEn) cnt++;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    int first;
    tick(3);
    // R9: reset state
    chk("R9 pinOe after reset", pinOe, 0);
    chk("R9 pinRead after reset", pinRead, 0);
    rst = 1'b0;

    // R1, R2: table walk
    for (int v = 0; v < NVEC; v++) begin
      psSel = VEC_CODE[v];
      cnt = 0;
      first = 0;
      for (int i = 1; i <= 100; i++) begin
        @(negedge clk);
        if (countEn) begin
          cnt++;
          if (first == 0) first = i;
        end
      end
      chk("R1 strobe count", cnt, VEC_COUNT[v]);
      chk("R2 first strobe after change", first, VEC_FIRST[v]);
    end

    // R6: general-purpose output
    psSel = 3'd0; pinDirOut = 1'b1; pinDataOut = 1'b1;
    tick(1);
    chk("R6 pinOe follows direction", pinOe, 1);
    chk("R6 pinOut follows data", pinOut, 1);
    pinDataOut = 1'b0;
    tick(1);
    chk("R6 pinOut follows data low", pinOut, 0);

    // R7: synchroniser latency
    pinIn = 1'b1;
    tick(1);
    chk("R7 pinRead after one edge", pinRead, 0);
    tick(1);
    chk("R7 pinRead after two edges", pinRead, 1);
    pinIn = 1'b0;
    tick(3);

    // R5: external select overrides direction
    psSel = 3'd7;
    tick(1);
    chk("R5 pinOe forced low", pinOe, 0);
    psSel = 3'd2;
    tick(1);
    chk("R6 pinOe restored", pinOe, 1);
    psSel = 3'd7;
    tick(3);

    // R3: edge latency and single pulse
    pinIn = 1'b1;
    tick(1);
    chk("R3 no pulse after first edge", countEn, 0);
    tick(1);
    chk("R3 pulse after second edge", countEn, 1);
    tick(1);
    chk("R3 pulse lasts one cycle", countEn, 0);

    // R4: steady high, then falling edge and steady low
    countPulses(10, cnt);
    chk("R4 steady high no pulse", cnt, 0);
    pinIn = 1'b0;
    countPulses(10, cnt);
    chk("R4 falling edge no pulse", cnt, 0);

    // R3: 2-high/2-low pattern, 10 rising edges
    cnt = 0;
    for (int e = 0; e < 10; e++) begin
      pinIn = 1'b1; @(negedge clk); if (countEn) cnt++;
      @(negedge clk); if (countEn) cnt++;
      pinIn = 1'b0; @(negedge clk); if (countEn) cnt++;
      @(negedge clk); if (countEn) cnt++;
    end
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (countEn) cnt++; end
    chk("R3 quarter-rate pulses", cnt, 10);

    // R3: half-rate input, 10 rising edges
    cnt = 0;
    for (int e = 0; e < 10; e++) begin
      pinIn = 1'b1; @(negedge clk); if (countEn) cnt++;
      pinIn = 1'b0; @(negedge clk); if (countEn) cnt++;
    end
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (countEn) cnt++; end
    chk("R3 half-rate pulses", cnt, 10);

    // R8: edge during stop is not released later
    stopReq = 1'b1;
    pinIn = 1'b1;
    countPulses(6, cnt);
    chk("R8 no pulse while stopped", cnt, 0);
    chk("R8 synchroniser tracks during stop", pinRead, 1);
    stopReq = 1'b0;
    countPulses(6, cnt);
    chk("R8 no stale pulse after stop", cnt, 0);
    pinIn = 1'b0;
    tick(3);

    // R8: stop with divide-by-one
    psSel = 3'd0;
    stopReq = 1'b1;
    countPulses(10, cnt);
    chk("R8 bus strobe held off", cnt, 0);
    stopReq = 1'b0;
    countPulses(10, cnt);
    chk("R1 bus strobe resumes", cnt, 10);

    // R9: reset mid-operation
    pinDirOut = 1'b1;
    psSel = 3'd3;
    tick(5);
    chk("R6 pinOe before reset", pinOe, 1);
    rst = 1'b1;
    tick(1);
    chk("R9 pinOe cleared by reset", pinOe, 0);
    rst = 1'b0;
    psSel = 3'd0;
    pinDirOut = 1'b0;
    tick(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule